// File: doc/BRIEF.md
# Modem-Line Flow Controller

This block handles automatic hardware flow control for a single serial channel. On the receive side it watches how full the receive FIFO is. It drives an active-low request-to-send line high (stop) once a high-water mark is reached, and low (go) again only after the count has drained to a low-water mark. Between those two marks the line keeps its last state. In the shallow (legacy) FIFO mode a 2-bit selector picks one of four fixed threshold pairs. In the deep FIFO mode the two marks come from programmable registers.

On the transmit side the block passes the remote clear-to-send line through a two-stage synchronizer. A 0-to-1 change on that line is a stop request. The block then withdraws its transmit-allowed signal. If a character is in flight, it waits for the transmitter's end-of-stop-bit strobe before doing so. The same stop request can set a sticky interrupt flag. A swap input moves the whole function onto the alternate modem pair: the stop request is taken from the data-set-ready line, and the request output drives data-terminal-ready.

Top module: `modem_flow_ctl`

## Requirements
- R1: After reset, `rts_n_out` and `dtr_n_out` are 0, `tx_allow` is 1 and `cts_irq` is 0.
- R2: In legacy mode (`wide_fifo`=0) the request line goes to 1 on the clock edge at which `rx_count` is at or above the high mark. The marks are 8, 16, 24 and 28 for `legacy_lvl` 0, 1, 2 and 3.
- R3: In legacy mode the request line returns to 0 on the edge at which `rx_count` is at or below the low mark (0, 7, 15, 23 for `legacy_lvl` 0..3). Between the marks it holds its state.
- R4: In deep mode (`wide_fifo`=1) the marks are `flow_hi` (go to 1 when the count is at or above it) and `flow_lo` (go to 0 when the count is at or below it), with hold in between. If both conditions are true, stop wins.
- R5: With `auto_rts_en`=0, both request outputs are 0 from the next edge on, whatever the count.
- R6: With `auto_cts_en`=1 and `tx_busy`=0, a 1 on the selected stop input drops `tx_allow` on the third rising edge after the input changes (two synchronizer stages plus one state register).
- R7: While `tx_busy`=1, `tx_allow` stays 1 under a stop request until a cycle with `stop_bit_done`=1. It is 0 from the edge that samples that strobe.
- R8: When the selected stop input returns to 0, `tx_allow` is 1 again on the third edge after the change.
- R9: With `auto_cts_en`=0, `tx_allow` is 1 and `cts_irq` is not set, whatever the stop inputs do.
- R10: A synchronized 0-to-1 change of the selected stop input sets `cts_irq` when `auto_cts_en` and `cts_irq_en` are both 1. The flag holds until `irq_clear`. If a set and a clear fall in the same cycle, the set wins. With `cts_irq_en`=0 the flag is not set.
- R11: With `pin_swap`=1, the stop request comes from `dsr_n_in` and `cts_n_in` is ignored. The request state drives `dtr_n_out`, and `rts_n_out` stays 0. With `pin_swap`=0 the roles are reversed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| wide_fifo | input | 1 | 1 = deep mode with programmable marks |
| legacy_lvl | input | 2 | Threshold pair selector for legacy mode |
| flow_hi | input | CNT_W | Deep-mode high-water mark |
| flow_lo | input | CNT_W | Deep-mode low-water mark |
| auto_rts_en | input | 1 | Enable automatic request output |
| auto_cts_en | input | 1 | Enable automatic transmit pause |
| cts_irq_en | input | 1 | Enable the stop-request interrupt flag |
| irq_clear | input | 1 | Clears the interrupt flag |
| pin_swap | input | 1 | Use the DSR/DTR pair instead of CTS/RTS |
| cts_n_in | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n_in | input | 1 | Data-set-ready, active low, asynchronous |
| tx_busy | input | 1 | A character is being shifted out |
| stop_bit_done | input | 1 | Strobe: the stop bit of the current character has finished |
| rts_n_out | output | 1 | Request-to-send, active low |
| dtr_n_out | output | 1 | Data-terminal-ready, active low |
| tx_allow | output | 1 | Transmitter may start a new character |
| cts_irq | output | 1 | Sticky stop-request interrupt flag |

## Verification
Two collisions between functions are possible in the same cycle. The first is a new stop-request edge and the software clear of the interrupt flag. The bench provokes it by raising the input again after a clear and pulsing `irq_clear` in exactly the cycle in which the synchronized edge reaches the flag register. It then expects the flag to be set. The second is a stop request meeting the end-of-stop-bit strobe while a character is busy. Here `tx_allow` must stay high through the busy period and fall on exactly the edge after the strobe. The receive thresholds are swept up and down across every legacy selector and several deep-mode pairs, with a hysteresis model held in the bench.

// File: rtl/modem_flow_ctl.sv
module modem_flow_ctl #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             wide_fifo,
  input  logic [1:0]       legacy_lvl,
  input  logic [CNT_W-1:0] flow_hi,
  input  logic [CNT_W-1:0] flow_lo,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic             cts_irq_en,
  input  logic             irq_clear,
  input  logic             pin_swap,
  input  logic             cts_n_in,
  input  logic             dsr_n_in,
  input  logic             tx_busy,
  input  logic             stop_bit_done,
  output logic             rts_n_out,
  output logic             dtr_n_out,
  output logic             tx_allow,
  output logic             cts_irq
);

  localparam int SMSB = SYNC_STAGES - 1;

  logic [CNT_W-1:0] hi_thr, lo_thr;
  logic             rx_stop;
  logic [SMSB:0]    cts_sync, dsr_sync;
  logic             line_stop, line_prev;
  logic             halted;
  logic             past_ok;

  always_comb begin
    hi_thr = flow_hi;
    lo_thr = flow_lo;
    if (!wide_fifo) begin
      unique case (legacy_lvl)
        2'd0: begin hi_thr = CNT_W'(8);  lo_thr = CNT_W'(0);  end
        2'd1: begin hi_thr = CNT_W'(16); lo_thr = CNT_W'(7);  end
        2'd2: begin hi_thr = CNT_W'(24); lo_thr = CNT_W'(15); end
        default: begin hi_thr = CNT_W'(28); lo_thr = CNT_W'(23); end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rx_stop <= 1'b0;
    else if (!auto_rts_en)      rx_stop <= 1'b0;
    else if (rx_count >= hi_thr) rx_stop <= 1'b1;
    else if (rx_count <= lo_thr) rx_stop <= 1'b0;
  end

  assign rts_n_out = !pin_swap && rx_stop;
  assign dtr_n_out =  pin_swap && rx_stop;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cts_sync <= '0;
          dsr_sync <= '0;
        end else begin
          cts_sync <= {cts_sync[SMSB-1:0], cts_n_in};
          dsr_sync <= {dsr_sync[SMSB-1:0], dsr_n_in};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cts_sync <= '0;
          dsr_sync <= '0;
        end else begin
          cts_sync <= cts_n_in;
          dsr_sync <= dsr_n_in;
        end
      end
    end
  endgenerate

  assign line_stop = pin_swap ? dsr_sync[SMSB] : cts_sync[SMSB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_prev <= 1'b0;
      halted    <= 1'b0;
      cts_irq   <= 1'b0;
      past_ok   <= 1'b0;
    end else begin
      line_prev <= line_stop;
      past_ok   <= 1'b1;
      if (!auto_cts_en || !line_stop)        halted <= 1'b0;
      else if (!tx_busy || stop_bit_done)    halted <= 1'b1;
      if (auto_cts_en && cts_irq_en && line_stop && !line_prev) cts_irq <= 1'b1;
      else if (irq_clear)                                       cts_irq <= 1'b0;
    end
  end

  assign tx_allow = !halted;

  p_stop_at_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(auto_rts_en && rx_count >= hi_thr) |-> (rts_n_out || dtr_n_out));

  p_hold_above_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(auto_rts_en && rx_stop && rx_count > lo_thr) |-> rx_stop);

  p_idle_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!auto_rts_en) |-> !(rts_n_out || dtr_n_out));

  p_finish_char_r7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(tx_allow && tx_busy && !stop_bit_done) |-> tx_allow);

  p_no_pause_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!auto_cts_en) |-> tx_allow);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(cts_irq && !irq_clear) |-> cts_irq);

  p_one_output_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rts_n_out && dtr_n_out));

endmodule

// File: tb/tb_modem_flow_ctl.sv
module tb_modem_flow_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CNT_W-1:0] rx_count = '0, flow_hi = '0, flow_lo = '0;
  logic wide_fifo = 0, auto_rts_en = 0, auto_cts_en = 0, cts_irq_en = 0;
  logic irq_clear = 0, pin_swap = 0, cts_n_in = 0, dsr_n_in = 0;
  logic tx_busy = 0, stop_bit_done = 0;
  logic [1:0] legacy_lvl = '0;
  logic rts_n_out, dtr_n_out, tx_allow, cts_irq;
  int checks = 0, errors = 0;
  bit model_stop;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_flow_ctl #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut (.*);

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step_count(input int v, input int hi, input int lo, input string tag);
    rx_count = CNT_W'(v);
    if (v >= hi) model_stop = 1;
    else if (v <= lo) model_stop = 0;
    tick(1);
    chk(pin_swap ? dtr_n_out : rts_n_out, model_stop, tag);
  endtask

  task automatic sweep(input int hi, input int lo, input int top, input string tag);
    model_stop = 0;
    step_count(0, hi, lo, tag);
    for (int v = 1; v <= top; v++) step_count(v, hi, lo, tag);
    for (int v = top; v >= 0; v--) step_count(v, hi, lo, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk(rts_n_out, 0, "R1 rts");
    chk(dtr_n_out, 0, "R1 dtr");
    chk(tx_allow, 1, "R1 allow");
    chk(cts_irq, 0, "R1 irq");

    auto_rts_en = 1;
    // R2 and R3: legacy sweeps
    for (int s = 0; s < 4; s++) begin
      int hi, lo;
      legacy_lvl = 2'(s);
      hi = (s == 3) ? 28 : 8 * (s + 1);
      lo = (s == 0) ? 0 : 8 * s - 1;
      sweep(hi, lo, 34, "R2/R3 legacy");
    end

    // R4: deep mode pairs
    wide_fifo = 1;
    flow_hi = 100; flow_lo = 60; sweep(100, 60, 130, "R4 deep");
    flow_hi = 128; flow_lo = 1;  sweep(128, 1, 130, "R4 deep");
    flow_hi = 5;   flow_lo = 4;  sweep(5, 4, 12, "R4 deep");
    flow_hi = 10;  flow_lo = 20; sweep(10, 20, 25, "R4 stop wins");

    // R11: request moves to DTR
    flow_hi = 50; flow_lo = 10;
    rx_count = 80; tick(1);
    chk(rts_n_out, 1, "R4 rts at high");
    pin_swap = 1; tick(1);
    chk(dtr_n_out, 1, "R11 dtr carries request");
    chk(rts_n_out, 0, "R11 rts idle");
    pin_swap = 0;

    // R5: disabled
    auto_rts_en = 0; tick(1);
    chk(rts_n_out, 0, "R5 rts off");
    chk(dtr_n_out, 0, "R5 dtr off");
    rx_count = 0;

    // R9: pause disabled
    cts_n_in = 1; tick(6);
    chk(tx_allow, 1, "R9 allow");
    chk(cts_irq, 0, "R9 irq");
    cts_n_in = 0; tick(4);

    // R6 and R10: idle stop request with interrupt
    auto_cts_en = 1; cts_irq_en = 1;
    cts_n_in = 1; tick(2);
    chk(tx_allow, 1, "R6 not yet");
    tick(1);
    chk(tx_allow, 0, "R6 halted");
    chk(cts_irq, 1, "R10 set");
    tick(3);
    chk(cts_irq, 1, "R10 sticky");
    irq_clear = 1; tick(1); irq_clear = 0;
    chk(cts_irq, 0, "R10 cleared");

    // R8: resume
    cts_n_in = 0; tick(2);
    chk(tx_allow, 0, "R8 not yet");
    tick(1);
    chk(tx_allow, 1, "R8 resumed");

    // R10: set and clear in same cycle
    cts_n_in = 1; tick(2);
    irq_clear = 1; tick(1); irq_clear = 0;
    chk(cts_irq, 1, "R10 set beats clear");
    irq_clear = 1; tick(1); irq_clear = 0;
    cts_n_in = 0; tick(4);

    // R10: interrupt disabled
    cts_irq_en = 0;
    cts_n_in = 1; tick(4);
    chk(cts_irq, 0, "R10 disabled");
    chk(tx_allow, 0, "R6 halted again");
    cts_n_in = 0; tick(4);
    cts_irq_en = 1;

    // R7: busy character completes first
    tx_busy = 1;
    cts_n_in = 1; tick(6);
    chk(tx_allow, 1, "R7 busy holds");
    stop_bit_done = 1; tick(1); stop_bit_done = 0;
    chk(tx_allow, 0, "R7 after stop bit");
    tx_busy = 0;
    cts_n_in = 0; tick(4);
    chk(tx_allow, 1, "R8 resumed after busy");
    irq_clear = 1; tick(1); irq_clear = 0;

    // R11: DSR replaces CTS
    pin_swap = 1; tick(2);
    cts_n_in = 1; tick(5);
    chk(tx_allow, 1, "R11 cts ignored");
    chk(cts_irq, 0, "R11 cts no irq");
    cts_n_in = 0; tick(3);
    dsr_n_in = 1; tick(3);
    chk(tx_allow, 0, "R11 dsr halts");
    chk(cts_irq, 1, "R11 dsr irq");
    dsr_n_in = 0; tick(3);
    chk(tx_allow, 1, "R11 dsr resume");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule